// File: doc/BRIEF.md
# Bounce-Immune Delay-Line Pulse Generator

This block is a series chain of contact-debounce stages, each clocked by a shared sample strobe. Every stage keeps its output until its input has differed from it on a fixed number of consecutive strobes. It then takes the input value. Because each stage feeds the next, the stage outputs form a tapped delay line, and each tap lags the one before it by that same number of strobes once the signal is steady. All taps and the contact input are active low.

A one-shot is taken from the first two taps. In make mode the output is high while the first tap is active and the second is still inactive. In break mode the output is high while the first tap has gone inactive and the second is still active. Both taps only move on clean, settled levels. The pulse therefore lasts exactly one stage delay for each contact operation, whatever the contact does while it bounces. The edge select is captured only while the first two taps agree, so a change of select can never cut a pulse short or start one partway through.

Top module: `debounce_pulse_chain`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, every tap reads 1 (inactive) and the pulse output reads 0.
- R2: Stage 0 takes the value of `contact_n` on the strobe (a cycle with `sample_en` = 1) that completes DEPTH (default 4) consecutive strobes on which the input differed from the stage output. The new value is visible from the following cycle.
- R3: A strobe on which a stage input equals its output discards any partial count, so bounces shorter than DEPTH strobes never move a tap.
- R4: Stage k (k > 0) uses tap k-1 as its input under the rule of R2, so with a steady input each tap changes DEPTH strobes after the one before it.
- R5: On a cycle with `sample_en` = 0 no tap changes.
- R6: With the select at 0 (make mode), `pulse` = 1 exactly when tap 0 = 0 and tap 1 = 1. This gives one pulse that spans DEPTH strobes for each settled contact closure.
- R7: With the select at 1 (break mode), `pulse` = 1 exactly when tap 0 = 1 and tap 1 = 0. This gives one pulse of DEPTH strobes for each settled contact release.
- R8: `sel_break` is captured on a clock edge only if taps 0 and 1 are equal before that edge. Otherwise the mode in force is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_en | input | 1 | Sample strobe; stages advance only on cycles where it is high |
| contact_n | input | 1 | Contact level, low = closed |
| sel_break | input | 1 | 0 = pulse on make, 1 = pulse on break |
| taps_n | output | STAGES (6) | Stage outputs, bit k = stage k, active low |
| pulse | output | 1 | One-shot output, active high |

## Verification
On every cycle the assertions check the following. A tap moves only on a strobe. When a tap moves, it moves to the value its input held before the edge. The pulse is only high while the first two taps disagree. Every pulse spans exactly DEPTH strobes. The captured mode holds while the first two taps differ. Only the bench scenarios can show the rest, by comparing against an independent model: that bounce shorter than DEPTH strobes leaves the taps untouched, that make and break each yield exactly one pulse, that a select change in mid-window neither truncates nor creates a pulse, and that sparse strobes stretch all delays.

// File: rtl/cdp_pkg.sv
package cdp_pkg;

  typedef enum logic {
    EDGE_MAKE  = 1'b0,
    EDGE_BREAK = 1'b1
  } edge_sel_e;

  // One-shot term: inverter on one tap, then NOR with the other tap.
  // Make : NOR(tap0_n, ~tap1_n) -> tap0 active, tap1 not yet.
  // Break: NOR(~tap0_n, tap1_n) -> tap0 released, tap1 not yet.
  function automatic logic shot_of(input logic first_n, input logic second_n,
                                   input edge_sel_e mode);
    logic a, b;
    a = (mode == EDGE_MAKE) ? first_n : ~first_n;
    b = (mode == EDGE_MAKE) ? ~second_n : second_n;
    return ~(a | b);
  endfunction

endpackage

// File: rtl/db_stage.sv
module db_stage #(
  parameter int DEPTH = 4,
  localparam int CW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic din_n,
  output logic dout_n,
  output logic flip
);

  logic [CW-1:0] run;
  logic          differ;
  logic          q_n;

  assign differ = (din_n != q_n);
  assign flip   = en && differ && (run == CW'(DEPTH - 1));
  assign dout_n = q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_n <= 1'b1;
      run <= '0;
    end else if (en) begin
      if (!differ) begin
        run <= '0;
      end else if (flip) begin
        q_n <= din_n;
        run <= '0;
      end else begin
        run <= run + 1'b1;
      end
    end
  end

endmodule

// File: rtl/edge_shot.sv
module edge_shot
  import cdp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sel_break,
  input  logic      first_n,
  input  logic      second_n,
  output edge_sel_e mode_q,
  output logic      mode_open,
  output logic      shot
);

  assign mode_open = (first_n == second_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= EDGE_MAKE;
    else if (mode_open) mode_q <= edge_sel_e'(sel_break);
  end

  assign shot = shot_of(first_n, second_n, mode_q);

endmodule

// File: rtl/debounce_pulse_chain.sv
module debounce_pulse_chain
  import cdp_pkg::*;
#(
  parameter int STAGES = 6,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_en,
  input  logic              contact_n,
  input  logic              sel_break,
  output logic [STAGES-1:0] taps_n,
  output logic              pulse
);

  logic [STAGES-1:0] stage_in_n;
  logic [STAGES-1:0] stage_flip;
  edge_sel_e         mode_q;
  logic              mode_open;

  generate
    for (genvar k = 0; k < STAGES; k++) begin : g_stage
      if (k == 0) begin : g_head
        assign stage_in_n[k] = contact_n;
      end else begin : g_link
        assign stage_in_n[k] = taps_n[k-1];
      end
      db_stage #(.DEPTH(DEPTH)) u_stage (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (sample_en),
        .din_n (stage_in_n[k]),
        .dout_n(taps_n[k]),
        .flip  (stage_flip[k])
      );
    end
  endgenerate

  edge_shot u_shot (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_break(sel_break),
    .first_n  (taps_n[0]),
    .second_n (taps_n[1]),
    .mode_q   (mode_q),
    .mode_open(mode_open),
    .shot     (pulse)
  );

endmodule

// File: rtl/debounce_pulse_chain_chk.sv
module debounce_pulse_chain_chk #(
  parameter int STAGES = 6,
  parameter int DEPTH  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sample_en,
  input logic              contact_n,
  input logic [STAGES-1:0] taps_n,
  input logic              pulse,
  input logic              mode_bit
);

  localparam int SW = $clog2(DEPTH + 2) + 1;
  logic [SW-1:0] shot_strobes;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shot_strobes <= '0;
    else if (!pulse) shot_strobes <= '0;
    else if (sample_en) shot_strobes <= shot_strobes + 1'b1;
  end

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_en |=> $stable(taps_n));

  assert_head_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (taps_n[0] != $past(taps_n[0])) |-> (taps_n[0] == $past(contact_n)));

  generate
    for (genvar k = 1; k < STAGES; k++) begin : g_link
      assert_link_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (taps_n[k] != $past(taps_n[k])) |-> (taps_n[k] == $past(taps_n[k-1])));
    end
  endgenerate

  assert_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> (taps_n[0] != taps_n[1]));

  assert_length_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pulse) |-> (shot_strobes == SW'(DEPTH)));

  assert_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (taps_n[0] != taps_n[1]) |=> $stable(mode_bit));

endmodule

bind debounce_pulse_chain debounce_pulse_chain_chk #(.STAGES(STAGES), .DEPTH(DEPTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sample_en(sample_en),
  .contact_n(contact_n),
  .taps_n   (taps_n),
  .pulse    (pulse),
  .mode_bit (mode_q)
);

// File: tb/sim_debounce_pulse_chain.sv
`timescale 1ns/1ps
module sim_debounce_pulse_chain;

  localparam int N = 6;
  localparam int D = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sample_en = 1'b0;
  logic contact_n = 1'b1;
  logic sel_break = 1'b0;
  logic [N-1:0] taps_n;
  logic pulse;

  always #4 clk = ~clk;

  debounce_pulse_chain #(.STAGES(N), .DEPTH(D)) u0 (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .contact_n(contact_n),
    .sel_break(sel_break), .taps_n(taps_n), .pulse(pulse)
  );

  int tests = 0;
  int fails = 0;
  int pulse_seen = 0;
  bit done = 0;

  logic [N-1:0] exp_taps_q[$];
  logic         exp_pulse_q[$];
  string        exp_tag_q[$];

  logic [N-1:0] m_tap = '1;
  int           m_cnt[N];
  logic         m_mode = 1'b0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // driver: apply inputs, advance the reference model, queue the expectation
  task automatic drive(input logic c, input logic e, input logic s, input string tag);
    logic [N-1:0] old;
    logic inb, exp_p;
    @(negedge clk);
    contact_n = c; sample_en = e; sel_break = s;
    old = m_tap;
    if (old[0] == old[1]) m_mode = s;
    if (e) begin
      for (int k = 0; k < N; k++) begin
        inb = (k == 0) ? c : old[k-1];
        if (inb == old[k]) m_cnt[k] = 0;
        else if (m_cnt[k] + 1 == D) begin m_tap[k] = inb; m_cnt[k] = 0; end
        else m_cnt[k]++;
      end
    end
    exp_p = m_mode ? (m_tap[0] && !m_tap[1]) : (!m_tap[0] && m_tap[1]);
    exp_taps_q.push_back(m_tap);
    exp_pulse_q.push_back(exp_p);
    exp_tag_q.push_back(tag);
  endtask

  // monitor: after each edge, compare against the oldest expectation
  always @(posedge clk) begin
    #2;
    if (exp_taps_q.size() > 0) begin
      logic [N-1:0] et;
      logic ep;
      string tg;
      et = exp_taps_q.pop_front();
      ep = exp_pulse_q.pop_front();
      tg = exp_tag_q.pop_front();
      check({tg, " taps"}, 32'(taps_n), 32'(et));
      check({tg, " pulse"}, 32'(pulse), 32'(ep));
      if (pulse) pulse_seen++;
    end
  end

  task automatic drain();
    while (exp_taps_q.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < N; k++) m_cnt[k] = 0;
    repeat (3) @(negedge clk);
    check("R1 taps in reset", 32'(taps_n), 32'(6'h3F));
    check("R1 pulse in reset", 32'(pulse), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 taps after release", 32'(taps_n), 32'(6'h3F));
    check("R1 pulse after release", 32'(pulse), 32'd0);

    // R2/R4/R6: clean closure in make mode, strobe every cycle
    pulse_seen = 0;
    for (int i = 0; i < 40; i++) drive(1'b0, 1'b1, 1'b0, "R2 R4 R6 make");
    drain();
    check("R6 make pulse strobes", 32'(pulse_seen), 32'(D));

    // R3: release bounces shorter than DEPTH keep taps low
    for (int i = 0; i < 3; i++) begin
      for (int j = 0; j < 3; j++) drive(1'b1, 1'b1, 1'b0, "R3 bounce");
      drive(1'b0, 1'b1, 1'b0, "R3 bounce");
    end
    drain();
    check("R3 taps untouched by bounce", 32'(taps_n), 32'd0);

    // R7: switch to break mode while taps agree, then a clean release
    for (int i = 0; i < 3; i++) drive(1'b0, 1'b1, 1'b1, "R7 set break");
    pulse_seen = 0;
    for (int i = 0; i < 40; i++) drive(1'b1, 1'b1, 1'b1, "R7 break");
    drain();
    check("R7 break pulse strobes", 32'(pulse_seen), 32'(D));

    // R5: sparse strobes, closure in break mode gives no pulse
    pulse_seen = 0;
    for (int i = 0; i < 90; i++) drive(1'b0, (i % 3) == 0, 1'b1, "R5 sparse strobe");
    drain();
    check("R5 R7 closure under break mode", 32'(pulse_seen), 32'd0);
    check("R5 taps after sparse run", 32'(taps_n), 32'd0);

    // R8: select changes while taps 0 and 1 differ; mode stays break
    pulse_seen = 0;
    for (int i = 0; i < 40; i++) drive(1'b1, 1'b1, (i < 5), "R8 mid-window select");
    drain();
    check("R8 no pulse from late select", 32'(pulse_seen), 32'd1 * D);
    pulse_seen = 0;
    for (int i = 0; i < 40; i++) drive(1'b0, 1'b1, 1'b0, "R8 make after capture");
    drain();
    check("R8 make pulse after capture", 32'(pulse_seen), 32'(D));

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule